// File: doc/BRIEF.md
# Completion Entry Bit-Insertion Packer

This block assembles a 512-bit completion entry from a user data word, a per-packet entry size and two 3-bit selectors. One selector picks where an error bit lands and the other picks where a color bit lands. Each selector indexes a table of seven bit offsets, counted from the entry LSB, that is fixed by parameters at build time. User data is laid down LSB-first into every position of the sized entry that neither inserted bit occupies, so the usable payload width is the entry size minus the number of bits inserted.

Packets arrive and leave on valid/ready streams, with one registered stage in between. A small read-only word window lets software read back the seven configured color/error offset pairs.

Top module: `cmpt_entry_packer`

## Requirements
- R1: After reset `out_valid_o` is 0, `conflict_o` is 0 and `in_ready_o` is 1.
- R2: Selector value k in 0..6 places the color bit at color offset k and the error bit at error offset k. Selector value 7 places no bit. The default color offsets for k=0..6 are 0,1,63,64,100,255,511. The default error offsets are 1,2,5,62,127,256,511.
- R3: User data bits are taken in order from bit 0 of `in_data_i`. Each one fills the next entry position, counting up from bit 0, that holds no inserted bit. Data bits beyond the usable width are dropped.
- R4: `in_size_i` selects the entry size: 0 is 64 bits, 1 is 128 bits, 2 is 256 bits and 3 is 512 bits. Every output bit at or above the selected size is 0.
- R5: An offset at or above the selected size is not placed. The user data then uses the positions the bit would have taken.
- R6: If both bits are selected and their offsets are equal and inside the entry, the error bit takes that position, the color bit is not placed, and `conflict_o` sets. The flag stays set until reset.
- R7: When a packet is accepted on a clock edge, `out_valid_o` and its entry appear right after that edge.
- R8: `in_ready_o` equals `!out_valid_o || out_ready_i`. While `out_valid_o` is high and `out_ready_i` is low, the held entry stays unchanged.
- R9: For byte address 0xBC4+4k with k=0..6, `reg_rdata_o` returns color offset k in bits [8:0] and error offset k in bits [24:16]. All other bits read 0. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input packet valid |
| in_ready_o | output | 1 | Input packet accepted when high with valid |
| in_data_i | input | 512 | User data, LSB first |
| in_size_i | input | 2 | Entry size code |
| in_col_idx_i | input | 3 | Color offset selector, 7 = none |
| in_err_idx_i | input | 3 | Error offset selector, 7 = none |
| in_color_bit_i | input | 1 | Color bit value |
| in_error_bit_i | input | 1 | Error bit value |
| out_valid_o | output | 1 | Entry valid |
| out_ready_i | input | 1 | Downstream ready |
| out_entry_o | output | 512 | Packed completion entry |
| conflict_o | output | 1 | Sticky offset collision flag |
| reg_addr_i | input | 12 | Register window byte address |
| reg_rdata_o | output | 32 | Register window read data |

## Verification
The hardest case to reach is the interaction between offset collisions and entry size. The error-wins rule applies only when both selected offsets match and lie inside the entry. A collision at offset 511 therefore counts only in the 512-bit size, and an offset beyond a small entry must silently give its slot back to data. The stimulus sweeps every color selector, error selector and size combination in an order where the first real collision comes partway through. This exposes both a wrongly early sticky flag and a wrongly placed color bit against an arithmetic model of the fill order.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;
  localparam int ENTRY_W = 512;
  localparam int POS_W   = $clog2(ENTRY_W);
  localparam int LIM_W   = POS_W + 1;
  localparam int IDX_W   = 3;
  localparam int NUM_OPT = 7;

  typedef enum logic [1:0] {SZ_8B = 2'd0, SZ_16B = 2'd1, SZ_32B = 2'd2, SZ_64B = 2'd3} size_e;

  function automatic logic [LIM_W-1:0] entry_bits(input logic [1:0] s);
    return LIM_W'(64) << s;
  endfunction
endpackage

// File: rtl/cmpt_pos_lut.sv
module cmpt_pos_lut
  import cmpt_pkg::*;
#(
  parameter logic [NUM_OPT*POS_W-1:0] TBL = '0
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [POS_W-1:0] pos_o,
  output logic             en_o
);
  always_comb begin
    pos_o = '0;
    en_o  = 1'b0;
    for (int k = 0; k < NUM_OPT; k++) begin
      if (idx_i == IDX_W'(k)) begin
        pos_o = TBL[k*POS_W +: POS_W];
        en_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmpt_bit_merge.sv
module cmpt_bit_merge
  import cmpt_pkg::*;
(
  input  logic [ENTRY_W-1:0] data_i,
  input  logic [1:0]         size_i,
  input  logic [POS_W-1:0]   col_pos_i,
  input  logic               col_en_i,
  input  logic [POS_W-1:0]   err_pos_i,
  input  logic               err_en_i,
  input  logic               col_bit_i,
  input  logic               err_bit_i,
  output logic [ENTRY_W-1:0] entry_o,
  output logic               conflict_o
);
  logic [LIM_W-1:0] lim;
  logic col_in, err_in, col_place, err_place;

  assign lim        = entry_bits(size_i);
  assign col_in     = col_en_i && ({1'b0, col_pos_i} < lim);
  assign err_in     = err_en_i && ({1'b0, err_pos_i} < lim);
  assign conflict_o = col_in && err_in && (col_pos_i == err_pos_i);
  assign err_place  = err_in;
  assign col_place  = col_in && !conflict_o;

  for (genvar j = 0; j < ENTRY_W; j++) begin : g_bit
    localparam logic [POS_W-1:0] JP = POS_W'(j);
    localparam logic [LIM_W-1:0] JL = LIM_W'(j);
    logic [1:0] skip;
    logic d0, d1, d2, dsel;
    assign skip = {1'b0, col_place && (col_pos_i < JP)} + {1'b0, err_place && (err_pos_i < JP)};
    assign d0 = data_i[j];
    if (j >= 1) begin : g_d1
      assign d1 = data_i[j-1];
    end else begin : g_n1
      assign d1 = 1'b0;
    end
    if (j >= 2) begin : g_d2
      assign d2 = data_i[j-2];
    end else begin : g_n2
      assign d2 = 1'b0;
    end
    assign dsel = (skip == 2'd0) ? d0 : (skip == 2'd1) ? d1 : d2;
    assign entry_o[j] = (JL >= lim)                    ? 1'b0      :
                        (err_place && err_pos_i == JP) ? err_bit_i :
                        (col_place && col_pos_i == JP) ? col_bit_i : dsel;
  end
endmodule

// File: rtl/cmpt_cfg_regs.sv
module cmpt_cfg_regs
  import cmpt_pkg::*;
#(
  parameter logic [NUM_OPT*POS_W-1:0] COL_TBL = '0,
  parameter logic [NUM_OPT*POS_W-1:0] ERR_TBL = '0,
  parameter int ADDR_W = 12,
  parameter int BASE   = 'hBC4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [31:0]       rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_OPT; k++) begin
      if (addr_i == ADDR_W'(BASE + 4*k)) begin
        rdata_o[POS_W-1:0]     = COL_TBL[k*POS_W +: POS_W];
        rdata_o[16 +: POS_W]   = ERR_TBL[k*POS_W +: POS_W];
      end
    end
  end
endmodule

// File: rtl/cmpt_entry_packer.sv
module cmpt_entry_packer
  import cmpt_pkg::*;
#(
  parameter logic [NUM_OPT*POS_W-1:0] COL_POS_TBL =
    {9'd511, 9'd255, 9'd100, 9'd64, 9'd63, 9'd1, 9'd0},
  parameter logic [NUM_OPT*POS_W-1:0] ERR_POS_TBL =
    {9'd511, 9'd256, 9'd127, 9'd62, 9'd5, 9'd2, 9'd1},
  parameter int REG_ADDR_W = 12,
  parameter int REG_BASE   = 'hBC4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic [ENTRY_W-1:0]    in_data_i,
  input  logic [1:0]            in_size_i,
  input  logic [IDX_W-1:0]      in_col_idx_i,
  input  logic [IDX_W-1:0]      in_err_idx_i,
  input  logic                  in_color_bit_i,
  input  logic                  in_error_bit_i,
  output logic                  out_valid_o,
  input  logic                  out_ready_i,
  output logic [ENTRY_W-1:0]    out_entry_o,
  output logic                  conflict_o,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  output logic [31:0]           reg_rdata_o
);
  logic [POS_W-1:0]   col_pos, err_pos;
  logic               col_en, err_en, hit;
  logic [ENTRY_W-1:0] packed_d, entry_q;
  logic [1:0]         size_q;
  logic               valid_q, conflict_q, accept;

  cmpt_pos_lut #(.TBL(COL_POS_TBL)) u_col_lut (.idx_i(in_col_idx_i), .pos_o(col_pos), .en_o(col_en));
  cmpt_pos_lut #(.TBL(ERR_POS_TBL)) u_err_lut (.idx_i(in_err_idx_i), .pos_o(err_pos), .en_o(err_en));

  cmpt_bit_merge u_merge (
    .data_i(in_data_i), .size_i(in_size_i),
    .col_pos_i(col_pos), .col_en_i(col_en),
    .err_pos_i(err_pos), .err_en_i(err_en),
    .col_bit_i(in_color_bit_i), .err_bit_i(in_error_bit_i),
    .entry_o(packed_d), .conflict_o(hit)
  );

  cmpt_cfg_regs #(
    .COL_TBL(COL_POS_TBL), .ERR_TBL(ERR_POS_TBL),
    .ADDR_W(REG_ADDR_W), .BASE(REG_BASE)
  ) u_regs (.addr_i(reg_addr_i), .rdata_o(reg_rdata_o));

  assign in_ready_o = !valid_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= 1'b0;
      entry_q    <= '0;
      size_q     <= SZ_8B;
      conflict_q <= 1'b0;
    end else begin
      if (accept) begin
        valid_q <= 1'b1;
        entry_q <= packed_d;
        size_q  <= in_size_i;
        if (hit) conflict_q <= 1'b1;
      end else if (out_ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign out_valid_o = valid_q;
  assign out_entry_o = entry_q;
  assign conflict_o  = conflict_q;

  a_r8_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_entry_o));
  a_r8_ready_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);
  a_r7_accept_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);
  a_r6_sticky_conflict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |=> conflict_o);
  a_r4_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((out_entry_o >> entry_bits(size_q)) == '0));
endmodule

// File: tb/cmpt_entry_packer_tb_top.sv
module cmpt_entry_packer_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_ready;
  logic [511:0] in_data = '0;
  logic [1:0]   in_size = '0;
  logic [2:0]   col_idx = 3'd7, err_idx = 3'd7;
  logic         col_bit = 1'b0, err_bit = 1'b0;
  logic         out_valid, out_ready = 1'b1;
  logic [511:0] out_entry;
  logic         conflict;
  logic [11:0]  reg_addr = '0;
  logic [31:0]  reg_rdata;

  int total = 0, bad = 0;
  bit exp_conf = 0;
  localparam int CPOS [7] = '{0, 1, 63, 64, 100, 255, 511};
  localparam int EPOS [7] = '{1, 2, 5, 62, 127, 256, 511};

  always #2.5 clk = ~clk;

  cmpt_entry_packer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_size_i(in_size), .in_col_idx_i(col_idx), .in_err_idx_i(err_idx),
    .in_color_bit_i(col_bit), .in_error_bit_i(err_bit), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_entry_o(out_entry), .conflict_o(conflict),
    .reg_addr_i(reg_addr), .reg_rdata_o(reg_rdata)
  );

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] model(input logic [511:0] d, input int sz, input int ci,
                                          input int ei, input logic cb, input logic eb);
    logic [511:0] r = '0;
    int lim = 64 << sz;
    int k = 0;
    bit cpl = (ci < 7) && (CPOS[ci % 7] < lim);
    bit epl = (ei < 7) && (EPOS[ei % 7] < lim);
    if (cpl && epl && CPOS[ci % 7] == EPOS[ei % 7]) cpl = 0;
    for (int j = 0; j < lim; j++) begin
      if (epl && j == EPOS[ei % 7]) r[j] = eb;
      else if (cpl && j == CPOS[ci % 7]) r[j] = cb;
      else begin r[j] = d[k]; k++; end
    end
    return r;
  endfunction

  function automatic bit collides(input int sz, input int ci, input int ei);
    int lim = 64 << sz;
    return (ci < 7) && (ei < 7) && (CPOS[ci % 7] == EPOS[ei % 7]) && (CPOS[ci % 7] < lim);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [511:0] da, db;
    #1;
    check("R1 out_valid", 512'(out_valid), 512'(0));
    check("R1 conflict", 512'(conflict), 512'(0));
    check("R1 in_ready", 512'(in_ready), 512'(1));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6 R7: full selector/size sweep, error selector outermost
    for (int ei = 0; ei < 8; ei++) begin
      for (int ci = 0; ci < 8; ci++) begin
        for (int sz = 0; sz < 4; sz++) begin
          logic [511:0] d;
          logic cb, eb;
          for (int w = 0; w < 16; w++) d[w*32 +: 32] = $urandom;
          if (((ci + sz) % 5) == 0) d = '1;
          cb = ((ci + ei + sz) % 2) == 0;
          eb = !cb;
          @(negedge clk);
          in_valid = 1'b1; out_ready = 1'b1;
          in_data = d; in_size = 2'(sz); col_idx = 3'(ci); err_idx = 3'(ei);
          col_bit = cb; err_bit = eb;
          @(posedge clk); #1;
          check("R7 valid after accept", 512'(out_valid), 512'(1));
          check("R2 R3 R4 R5 entry", out_entry, model(d, sz, ci, ei, cb, eb));
          if (collides(sz, ci, ei)) exp_conf = 1;
          check("R6 conflict flag", 512'(conflict), 512'(exp_conf));
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    check("R7 idle drains", 512'(out_valid), 512'(0));

    // R8 backpressure
    da = {16{32'hA5C3_0F1E}};
    db = {16{32'h1234_5678}};
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = da; in_size = 2'd1;
    col_idx = 3'd2; err_idx = 3'd3; col_bit = 1'b1; err_bit = 1'b1;
    @(posedge clk); #1;
    check("R8 first held", out_entry, model(da, 1, 2, 3, 1'b1, 1'b1));
    @(negedge clk);
    in_data = db; in_size = 2'd3; col_idx = 3'd6; err_idx = 3'd7; col_bit = 1'b1;
    #1 check("R8 ready low", 512'(in_ready), 512'(0));
    @(posedge clk); #1;
    check("R8 stall keeps entry", out_entry, model(da, 1, 2, 3, 1'b1, 1'b1));
    @(negedge clk);
    out_ready = 1'b1;
    #1 check("R8 ready follows out_ready", 512'(in_ready), 512'(1));
    @(posedge clk); #1;
    check("R8 next entry", out_entry, model(db, 3, 6, 7, 1'b1, 1'b0));
    @(negedge clk);
    in_valid = 1'b0;

    // R9 register window
    for (int k = 0; k < 7; k++) begin
      reg_addr = 12'(12'hBC4 + 4*k);
      #1 check("R9 cfg word", 512'(reg_rdata),
               512'({7'd0, 9'(EPOS[k]), 7'd0, 9'(CPOS[k])}));
    end
    reg_addr = 12'hBC0; #1 check("R9 below window", 512'(reg_rdata), 512'(0));
    reg_addr = 12'hBE0; #1 check("R9 above window", 512'(reg_rdata), 512'(0));
    reg_addr = 12'hBC6; #1 check("R9 unaligned", 512'(reg_rdata), 512'(0));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule